// File: doc/BRIEF.md
# Pattern-Restarted Programmable Watchdog

This block is a watchdog counter for a processor supervisor. It counts 100 ms ticks from a shared timebase and compares the count with a period that the host programs in whole ticks. The counter always runs, including when the watchdog is disabled. When the counter reaches the period it starts again from zero. If the enable bit is set at that moment, the block also emits a one-cycle timeout pulse, which a separate reset generator turns into a reset pulse.

The host changes settings through a small byte-wide register write port. A control register holds the period field and the enable bit. A period written there does not take effect until the host writes the restart key to the restart register. That key write clears the counter and copies the programmed period into the working period. Any other value written to the restart register is ignored.

The all-ones period stops the counter, and a period of zero never fires. The counter is held at zero while the supply is below its trip point. The counter also clears when the reset generator reports the end of a reset pulse.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `timeout` is low. The working period is zero, so ticks produce no pulse until the first restart, even if the control register has already been written.
- R2: A write to address 0x0A stores data bits 4:0 as the programmed period, counted in ticks, and stores data bit 7 as the enable bit. The enable bit takes effect at once. The stored period does not change the working period until the next restart.
- R3: A write to address 0x09 whose data bits 3:0 equal 4'b1010 is a restart, whatever the upper bits hold. It clears the counter and loads the programmed period as the working period.
- R4: A write to address 0x09 with any other value in data bits 3:0 has no effect on the counter or on the working period.
- R5: With a working period N from 1 to 30, the supply good and enable set, the Nth tick after a restart or a previous timeout makes `timeout` high for exactly one cycle. That cycle is the cycle after the tick. The count then starts again from zero.
- R6: With enable clear, the counter still counts and wraps at the period, and no pulse is produced. Setting enable later lets the pulse come at the running count's next match.
- R7: A working period of 5'b11111 stops the counter, and a working period of 5'b00000 never produces a pulse.
- R8: While `supply_ok` is low, the counter is held at zero, ticks are ignored and no pulse is produced. When the supply returns, counting starts again from zero.
- R9: A one-cycle `rst_release` pulse clears the counter and leaves the working period unchanged.
- R10: A restart or `rst_release` in the same cycle as a tick wins. That tick is not counted and cannot produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address (0x09 restart, 0x0A control) |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | One-cycle pulse every 100 ms from the timebase |
| supply_ok | input | 1 | High while the supply is above the trip point |
| rst_release | input | 1 | One-cycle pulse when a reset pulse ends |
| timeout | output | 1 | One-cycle pulse on an enabled timeout |

## Verification
Some properties are checked on every cycle. A pulse only follows a tick that arrived with both the supply and the enable high. A restart key, or a reset release, always leaves the counter at zero. The working period changes only on a restart, and a foreign value written to the restart register leaves the counter untouched.

Other behaviour can only be shown by the bench scenarios:
- The exact tick on which a pulse lands for several periods, including the boundary periods of 1 and 30.
- The effect of reprogramming without a restart.
- The hidden progress of a disabled counter.
- The silence of the stop and zero periods over many ticks.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int TW = 5,
  parameter int KW = 4,
  parameter int EN_BIT = 7,
  parameter logic [AW-1:0] RESTART_ADDR = 8'h09,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h0A,
  parameter logic [KW-1:0] KEY = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tick,
  input  logic          supply_ok,
  input  logic          rst_release,
  output logic          timeout
);
  localparam logic [TW-1:0] STOP_VAL = '1;
  localparam logic [TW-1:0] ZERO_VAL = '0;

  logic [TW-1:0] prog_to, live_to, count_q, cnt_inc;
  logic          en_q, timeout_q;
  logic          restart, ctrl_wr, armed, hit, clear;
  logic          unused_data;

  assign unused_data = ^wr_data;
  assign restart = wr_en && (wr_addr == RESTART_ADDR) && (wr_data[KW-1:0] == KEY);
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  assign armed   = supply_ok && (live_to != ZERO_VAL) && (live_to != STOP_VAL);
  assign clear   = !supply_ok || restart || rst_release;
  assign cnt_inc = count_q + 1'b1;
  assign hit     = tick && armed && !clear && (cnt_inc == live_to);
  assign timeout = timeout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_to <= '0;
      en_q    <= 1'b0;
    end else if (ctrl_wr) begin
      prog_to <= wr_data[TW-1:0];
      en_q    <= wr_data[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       live_to <= '0;
    else if (restart) live_to <= prog_to;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                count_q <= '0;
    else if (clear)            count_q <= '0;
    else if (hit)              count_q <= '0;
    else if (tick && armed)    count_q <= cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) timeout_q <= 1'b0;
    else        timeout_q <= hit && en_q;
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int TW = 5,
  parameter int KW = 4,
  parameter logic [AW-1:0] RESTART_ADDR = 8'h09,
  parameter logic [KW-1:0] KEY = 4'b1010
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          tick,
  input logic          supply_ok,
  input logic          rst_release,
  input logic          timeout,
  input logic          en_q,
  input logic [TW-1:0] live_to,
  input logic [TW-1:0] count_q
);
  logic key_wr, other_wr, unused_chk;
  assign unused_chk = ^wr_data;
  assign key_wr   = wr_en && (wr_addr == RESTART_ADDR) && (wr_data[KW-1:0] == KEY);
  assign other_wr = wr_en && (wr_addr == RESTART_ADDR) && (wr_data[KW-1:0] != KEY);

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> $past(tick)); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> $past(en_q)); // R6
  AST_SUPPLY_GATES: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> $past(supply_ok)); // R8
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (live_to == '0 || live_to == '1) |-> count_q == '0); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) key_wr |=> (count_q == '0) && !timeout); // R3
  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n) !key_wr |=> $stable(live_to)); // R2
  AST_FOREIGN_KEY: assert property (@(posedge clk) disable iff (!rst_n) (other_wr && !tick && !rst_release && supply_ok) |=> $stable(count_q) && $stable(live_to)); // R4
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rst_release |=> (count_q == '0) && $stable(live_to)); // R9
  AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n) (tick && (key_wr || rst_release)) |=> !timeout); // R10
endmodule

bind wdog_timer wdog_timer_chk #(
  .AW(AW), .DW(DW), .TW(TW), .KW(KW), .RESTART_ADDR(RESTART_ADDR), .KEY(KEY)
) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tick(tick), .supply_ok(supply_ok), .rst_release(rst_release), .timeout(timeout),
  .en_q(en_q), .live_to(live_to), .count_q(count_q)
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;
  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0, supply_ok = 1, rst_release = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic timeout;
  logic sup = 1;
  int vectors = 0, fails = 0;
  bit exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  wdog_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .supply_ok(supply_ok),
    .rst_release(rst_release), .timeout(timeout));

  task automatic cyc(input logic t, input logic we, input logic [7:0] a,
                     input logic [7:0] d, input logic r, input bit e, input string tag);
    tick = t; wr_en = we; wr_addr = a; wr_data = d; rst_release = r; supply_ok = sup;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    tick = 0; wr_en = 0; rst_release = 0;
  endtask

  task automatic tk(input bit e, input string tag);
    cyc(1, 0, 8'h00, 8'h00, 0, e, tag);
    cyc(0, 0, 8'h00, 8'h00, 0, 0, tag);
  endtask

  task automatic tks(input int n, input string tag);
    for (int i = 0; i < n; i++) tk(0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    cyc(0, 1, a, d, 0, 0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        vectors++;
        if (timeout !== e) begin
          fails++;
          $display("FAIL %s: timeout=%b expected=%b at %0t", tg, timeout, e, $time);
        end
      end
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    vectors++;
    if (timeout !== 1'b0) begin
      fails++;
      $display("FAIL R1: timeout=%b expected=0 after reset", timeout);
    end
    // R1: programmed but never restarted -> working period zero
    wr(8'h0A, 8'h83, "R1");
    tks(5, "R1");
    // R3: key with junk upper bits, then R5 reload
    wr(8'h09, 8'hFA, "R3");
    tk(0, "R3"); tk(0, "R3"); tk(1, "R3");
    tk(0, "R5"); tk(0, "R5"); tk(1, "R5");
    // R2: new period held until restart
    wr(8'h0A, 8'h85, "R2");
    tk(0, "R2"); tk(0, "R2"); tk(1, "R2");
    wr(8'h09, 8'h0A, "R2");
    tks(4, "R2"); tk(1, "R2");
    // R4: foreign patterns ignored
    tks(2, "R4");
    wr(8'h09, 8'h05, "R4");
    wr(8'h09, 8'h0B, "R4");
    tk(0, "R4"); tk(0, "R4"); tk(1, "R4");
    // R6: disabled counter keeps running
    wr(8'h0A, 8'h03, "R6");
    wr(8'h09, 8'h0A, "R6");
    tks(3, "R6");
    tks(2, "R6");
    wr(8'h0A, 8'h83, "R6");
    tk(1, "R6");
    // R9: release clears count
    wr(8'h09, 8'h0A, "R9");
    tks(2, "R9");
    cyc(0, 0, 8'h00, 8'h00, 1, 0, "R9");
    tk(0, "R9"); tk(0, "R9"); tk(1, "R9");
    // R10: restart or release beats a tick
    wr(8'h09, 8'h0A, "R10");
    tks(2, "R10");
    cyc(1, 1, 8'h09, 8'h0A, 0, 0, "R10");
    tk(0, "R10"); tk(0, "R10"); tk(1, "R10");
    tks(2, "R10");
    cyc(1, 0, 8'h00, 8'h00, 1, 0, "R10");
    tk(0, "R10"); tk(0, "R10"); tk(1, "R10");
    // R8: supply low holds counter
    wr(8'h09, 8'h0A, "R8");
    tks(2, "R8");
    sup = 0;
    cyc(0, 0, 8'h00, 8'h00, 0, 0, "R8");
    tks(4, "R8");
    sup = 1;
    tk(0, "R8"); tk(0, "R8"); tk(1, "R8");
    // R7: stop value and zero value
    wr(8'h0A, 8'h9F, "R7");
    wr(8'h09, 8'h0A, "R7");
    tks(40, "R7");
    wr(8'h0A, 8'h80, "R7");
    wr(8'h09, 8'h0A, "R7");
    tks(40, "R7");
    // R5 boundaries: period 1 and period 30
    wr(8'h0A, 8'h81, "R5");
    wr(8'h09, 8'h0A, "R5");
    tk(1, "R5"); tk(1, "R5"); tk(1, "R5");
    wr(8'h0A, 8'h9E, "R5");
    wr(8'h09, 8'h0A, "R5");
    tks(29, "R5"); tk(1, "R5");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule